// File: doc/BRIEF.md
# Zero-Operand Scan Counter

This block holds two small register files of equal depth and counts how many index positions hold a zero word in at least one of them. Software or a neighbouring block loads both files through two independent write ports. A single-cycle start pulse then launches a sequenced scan. A controller walks an index from the first entry to the last. For each index it fetches the word from each file into operand registers, tests the pair, and advances. A position counts once when either word is zero, and also once when both are.

When the last index has been tested, the accumulated count moves into a dedicated result register. A done flag goes high for exactly one cycle on the same edge. The result holds its value until the next scan completes. Each scan costs a fixed three cycles per entry, plus one cycle to initialise and one to commit, so the completion time is known in advance.

Top module: `zero_scan_counter`

## Requirements
- R1: While reset (rst_n low, asynchronous) is applied and after it is released, `done` is 0 and `result` is 0, and both files read as all-zero words.
- R2: At the end of a scan, `result` equals the number of indices i in 0..DEPTH-1 for which file A word i is zero or file B word i is zero. An index where both are zero adds exactly one.
- R3: `done` is high for exactly one cycle. It rises after the clock edge that is 3*DEPTH+2 edges later than the edge that sampled `start` high in the idle state.
- R4: `result` changes only on the edge where `done` rises, and otherwise holds its previous value.
- R5: A `start` pulse seen while a scan is in progress, including its commit cycle, is ignored. It neither restarts the scan nor produces an extra `done` pulse.
- R6: Without a `start` pulse no scan runs, and `done` stays 0.
- R7: A write with `wr_en_a` (or `wr_en_b`) high stores `wr_data_a` (`wr_data_b`) at `wr_addr_a` (`wr_addr_b`) on the rising clock edge. A write to an address of DEPTH or higher changes no entry.
- R8: The count covers its full range. When every word in both files is nonzero the result is 0, and when every word of one file is zero the result is DEPTH (10 by default).
- R9: Every scan starts its count from zero, so a result never includes counts from an earlier scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a scan |
| wr_en_a | input | 1 | Write enable for file A |
| wr_addr_a | input | ADDR_W | Write address for file A |
| wr_data_a | input | DATA_W | Write data for file A |
| wr_en_b | input | 1 | Write enable for file B |
| wr_addr_b | input | ADDR_W | Write address for file B |
| wr_data_b | input | DATA_W | Write data for file B |
| result | output | CNT_W | Count from the latest completed scan |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The bench loads a pattern that has a zero in only A, a zero in only B, and a zero in both at one index. A design that joined the two tests with AND would report too few, and one that added the two tests separately would report one too many. It also runs an all-nonzero scan and a scan with every word of one file zero, which exposes counters that are too narrow or that skip the first or last index. A start pulse placed in the middle of a scan catches a controller that restarts, since that moves or doubles the done pulse. Back-to-back scans catch a count that is not cleared, and an out-of-range write catches address decoding that wraps.

// File: rtl/zsc_pkg.sv
package zsc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_INIT  = 3'd1,
      ST_READ  = 3'd2,
      ST_CHECK = 3'd3,
      ST_NEXT  = 3'd4,
      ST_DONE  = 3'd5
   } zsc_state_e;
endpackage

// File: rtl/zsc_regfile.sv
module zsc_regfile #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 10,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] words [DEPTH];

   // one register per entry; addresses at or above DEPTH match no entry (R7)
   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[g] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(g))) begin
            words[g] <= wr_data;
         end
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = words[i];
      end
   end
endmodule

// File: rtl/zsc_ctrl.sv
module zsc_ctrl
   import zsc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic last_idx,
   output logic clr,
   output logic load_ops,
   output logic test_ops,
   output logic advance,
   output logic commit
);
   zsc_state_e state, state_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:  if (start) state_nx = ST_INIT;
         ST_INIT:  state_nx = ST_READ;
         ST_READ:  state_nx = ST_CHECK;
         ST_CHECK: state_nx = ST_NEXT;
         ST_NEXT:  state_nx = last_idx ? ST_DONE : ST_READ;
         ST_DONE:  state_nx = ST_IDLE;
         default:  state_nx = ST_IDLE;
      endcase
   end

   assign clr      = (state == ST_INIT);
   assign load_ops = (state == ST_READ);
   assign test_ops = (state == ST_CHECK);
   assign advance  = (state == ST_NEXT) && !last_idx;
   assign commit   = (state == ST_DONE);

   // R5: start seen during a scan never re-enters the init state
   assert_busy_start_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE && start) |=> (state != ST_INIT));
   // R6: init is entered only from idle with start high
   assert_init_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_INIT) |-> ($past(state) == ST_IDLE && $past(start)));
   assert_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clr, load_ops, test_ops, state == ST_NEXT, commit}));
endmodule

// File: rtl/zsc_datapath.sv
module zsc_datapath #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 10,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              load_ops,
   input  logic              test_ops,
   input  logic              advance,
   input  logic              commit,
   input  logic [DATA_W-1:0] word_a,
   input  logic [DATA_W-1:0] word_b,
   output logic [ADDR_W-1:0] idx,
   output logic              last_idx,
   output logic [CNT_W-1:0]  result,
   output logic              done
);
   logic [DATA_W-1:0] op_a, op_b;
   logic [CNT_W-1:0]  cnt;
   logic              hit;

   assign last_idx = (idx == ADDR_W'(DEPTH - 1));
   assign hit      = (op_a == '0) || (op_b == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx    <= '0;
         cnt    <= '0;
         op_a   <= '0;
         op_b   <= '0;
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= commit;
         if (clr) begin
            idx <= '0;
            cnt <= '0;
         end
         if (advance)           idx  <= idx + 1'b1;
         if (load_ops) begin
            op_a <= word_a;
            op_b <= word_b;
         end
         if (test_ops && hit)   cnt  <= cnt + 1'b1;
         if (commit)            result <= cnt;
      end
   end

   assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH));
   assert_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx <= ADDR_W'(DEPTH - 1));
   assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(result));
   // R2/R9: the count only clears or steps by one
   assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/zero_scan_counter.sv
module zero_scan_counter #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 10,
   parameter int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              wr_en_a,
   input  logic [ADDR_W-1:0] wr_addr_a,
   input  logic [DATA_W-1:0] wr_data_a,
   input  logic              wr_en_b,
   input  logic [ADDR_W-1:0] wr_addr_b,
   input  logic [DATA_W-1:0] wr_data_b,
   output logic [CNT_W-1:0]  result,
   output logic              done
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("DATA_W must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if ((1 << ADDR_W) < DEPTH) begin : g_bad_addr_w
      $error("ADDR_W too narrow for DEPTH");
   end
   if ((1 << CNT_W) <= DEPTH) begin : g_bad_cnt_w
      $error("CNT_W too narrow to hold DEPTH");
   end

   logic              clr, load_ops, test_ops, advance, commit, last_idx;
   logic [ADDR_W-1:0] idx;
   logic [DATA_W-1:0] word_a, word_b;

   zsc_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file_a (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_a), .wr_addr(wr_addr_a),
      .wr_data(wr_data_a), .rd_addr(idx), .rd_data(word_a));

   zsc_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_file_b (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_b), .wr_addr(wr_addr_b),
      .wr_data(wr_data_b), .rd_addr(idx), .rd_data(word_b));

   zsc_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .last_idx(last_idx),
      .clr(clr), .load_ops(load_ops), .test_ops(test_ops),
      .advance(advance), .commit(commit));

   zsc_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
      .clk(clk), .rst_n(rst_n), .clr(clr), .load_ops(load_ops),
      .test_ops(test_ops), .advance(advance), .commit(commit),
      .word_a(word_a), .word_b(word_b), .idx(idx), .last_idx(last_idx),
      .result(result), .done(done));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!done && result == '0) or rst_n);
endmodule

// File: tb/tb_zero_scan_counter.sv
module tb_zero_scan_counter;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 10;
   localparam int ADDR_W = 4;
   localparam int CNT_W  = 4;
   localparam int LAT    = 3 * DEPTH + 2;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic wr_en_a = 1'b0, wr_en_b = 1'b0;
   logic [ADDR_W-1:0] wr_addr_a = '0, wr_addr_b = '0;
   logic [DATA_W-1:0] wr_data_a = '0, wr_data_b = '0;
   logic [CNT_W-1:0] result;
   logic done;

   int checks = 0, failures = 0;
   int ref_a [DEPTH];
   int ref_b [DEPTH];
   int m_busy = 0, m_cd = 0, m_pend = 0, m_res = 0, m_done = 0;
   int done_seen = 0;

   always #10 clk = ~clk;

   zero_scan_counter #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .start(start),
      .wr_en_a(wr_en_a), .wr_addr_a(wr_addr_a), .wr_data_a(wr_data_a),
      .wr_en_b(wr_en_b), .wr_addr_b(wr_addr_b), .wr_data_b(wr_data_b),
      .result(result), .done(done));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference, advanced on every rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_cd = 0; m_res = 0; m_done = 0;
         for (int i = 0; i < DEPTH; i++) begin ref_a[i] = 0; ref_b[i] = 0; end
      end else begin
         m_done = 0;
         if (m_busy != 0) begin
            m_cd--;
            if (m_cd == 0) begin m_busy = 0; m_done = 1; m_res = m_pend; end
         end else if (start) begin
            m_pend = 0;
            for (int i = 0; i < DEPTH; i++)
               if (ref_a[i] == 0 || ref_b[i] == 0) m_pend++;
            m_busy = 1; m_cd = LAT;
         end
         if (wr_en_a && int'(wr_addr_a) < DEPTH) ref_a[wr_addr_a] = int'(wr_data_a);
         if (wr_en_b && int'(wr_addr_b) < DEPTH) ref_b[wr_addr_b] = int'(wr_data_b);
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(done == m_done[0], "R3 done timing", int'(done), m_done);
         check(int'(result) == m_res, "R4 result", int'(result), m_res);
         if (done) done_seen++;
      end
   end

   task automatic wr_a(input int addr, input int data);
      @(negedge clk); wr_en_a = 1'b1; wr_addr_a = ADDR_W'(addr); wr_data_a = DATA_W'(data);
      @(negedge clk); wr_en_a = 1'b0;
   endtask

   task automatic wr_b(input int addr, input int data);
      @(negedge clk); wr_en_b = 1'b1; wr_addr_b = ADDR_W'(addr); wr_data_b = DATA_W'(data);
      @(negedge clk); wr_en_b = 1'b0;
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // run one scan, return latency in cycles after the start edge
   task automatic scan(output int lat, input int mid_start);
      lat = -1;
      pulse_start();
      for (int k = 1; k <= 200; k++) begin
         if (k == mid_start || k == LAT) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (done) begin lat = k; break; end
      end
   endtask

   initial begin
      int lat, n0;
      int pa [DEPTH] = '{0, 5, 0, 7, 1, 2, 3, 0, 9, 4};
      int pb [DEPTH] = '{3, 0, 0, 8, 6, 0, 1, 2, 5, 7};
      repeat (3) @(negedge clk);
      check(done == 1'b0, "R1 done in reset", int'(done), 0);
      check(result == '0, "R1 result in reset", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done == 1'b0 && result == '0, "R1 after release", int'(result), 0);

      // R6: idle with no start
      n0 = done_seen;
      repeat (50) @(negedge clk);
      check(done_seen == n0, "R6 no done without start", done_seen - n0, 0);

      // R1: fresh files read as zero words -> every index hits
      scan(lat, 0);
      check(int'(result) == DEPTH, "R1 reset contents zero", int'(result), DEPTH);

      // R2: mixed pattern with a both-zero index -> 5
      for (int i = 0; i < DEPTH; i++) begin wr_a(i, pa[i]); wr_b(i, pb[i]); end
      scan(lat, 0);
      check(lat == LAT, "R3 latency", lat, LAT);
      check(int'(result) == 5, "R2 mixed pattern count", int'(result), 5);

      // R8: all nonzero -> 0; R9 count cleared
      for (int i = 0; i < DEPTH; i++) begin wr_a(i, i + 1); wr_b(i, 200 - i); end
      // R7: out-of-range zero writes change nothing
      wr_a(DEPTH, 0); wr_b(15, 0); wr_a(12, 0);
      scan(lat, 0);
      check(int'(result) == 0, "R8 R9 R7 all nonzero count", int'(result), 0);

      // R8: all of file A zero -> DEPTH
      for (int i = 0; i < DEPTH; i++) wr_a(i, 0);
      scan(lat, 0);
      check(int'(result) == DEPTH, "R8 full count", int'(result), DEPTH);

      // R5: start during scan and on the commit cycle ignored
      wr_a(3, 9); wr_a(9, 8);
      n0 = done_seen;
      scan(lat, 7);
      check(lat == LAT, "R5 latency with mid start", lat, LAT);
      check(int'(result) == DEPTH - 2, "R5 count with mid start", int'(result), DEPTH - 2);
      repeat (LAT + 5) @(negedge clk);
      check(done_seen - n0 == 1, "R5 single done", done_seen - n0, 1);

      // R4: result holds after done
      check(int'(result) == DEPTH - 2, "R4 result held", int'(result), DEPTH - 2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule